// File: doc/BRIEF.md
# Serial Audio to Biphase-Mark Line Transmitter

The block takes one stereo pair of PCM samples per frame from a three-wire serial audio link (bit clock, word select, data) and emits a biphase-mark coded line signal in the AES3 style. The word select line marks the channel: low means left, high means right. The three serial inputs are oversampled by the single block clock `clk_i`, which must run at 128 times the frame rate, so each serial bit clock period spans exactly two `clk_i` cycles and each channel half-frame carries 32 bit clocks.

A deserialiser pulls each word out of the serial stream at a position set by the framing mode and word width. It then aligns the word to the top of a 24-bit field. Each completed left/right pair goes to a one-entry holding register. A frame sequencer takes the pair from that register at every frame boundary and builds two 32-slot subframes from it: a preamble, the audio field, then validity, user, channel-status and parity slots. A line encoder turns each slot into two half-cells. The sequencer also counts frames within a 192-frame block to choose the block-start preamble and the channel-status bit.

Top module: `aes_bmc_tx`

## Requirements
- R1: After reset `line_o` is low and stays low until the first complete left-then-right pair has been captured; the first half-cell after that is high.
- R2: With `fmt_i` = 0 (left-justified) or 3 (treated the same), the word MSB is the bit sampled on the first bit-clock rising edge after a word-select change.
- R3: With `fmt_i` = 1 (I2S), the MSB is the bit sampled on the second bit-clock rising edge after a word-select change.
- R4: With `fmt_i` = 2 (right-justified), the LSB is the bit sampled on the 32nd bit-clock rising edge after a word-select change, the last one before the next change.
- R5: `wsel_i` selects the word width: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. The word fills the top of the 24-bit audio field and the unused low bits are zero. The field sits in slots 4 to 27 and is sent LSB first, so slot 4 carries field bit 0.
- R6: Each frame is 128 `clk_i` cycles long: the left subframe (64 half-cells) and then the right subframe. Slot 28 carries `validity_i`, slot 29 is zero, and slot 31 is set so that slots 4 to 31 hold an even number of ones.
- R7: Slots 0 to 3 carry an 8-half-cell preamble. The block-start preamble 11101000 is used on the left subframe of frame 0 of each 192-frame block. 11100010 is used on the other left subframes and 11100100 on every right subframe. Each pattern is given first half-cell first, for a preceding line level of 0, and is inverted when the preceding level is 1.
- R8: In slots 4 to 31 the line changes level at every slot boundary, and changes again at mid-slot when the slot bit is 1.
- R9: Slot 30 of both subframes in frame k of a block carries bit k of `CS_PATTERN` for k below `CS_BITS`, and zero for the other frames.
- R10: When no new pair is waiting at a frame boundary, the previous pair is sent again and the frame count keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Encoder clock, 128 times the frame rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| ws_i | input | 1 | Word select: 0 for left, 1 for right |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 left-justified |
| wsel_i | input | 2 | Word width: 16, 18, 20 or 24 bits |
| validity_i | input | 1 | Value sent in the validity slot |
| line_o | output | 1 | Biphase-mark coded line signal |

## Verification
Two things can happen on the same clock edge: the deserialiser writes a fresh pair into the holding register, and the sequencer reads that register at a frame boundary. The same edge can also wrap the 192-frame counter. When the input runs at exactly the frame rate, these events fall one cycle apart on every frame. A long stream across a block wrap forces them together repeatedly. The bench decodes the line and checks that every sample arrives once and in order, and that the block-start preamble appears at frame 0 and again at frame 192. Stopping the input then shows the pair being repeated.

// File: rtl/abt_pkg.sv
`timescale 1ns/1ps
package abt_pkg;
  localparam int AUD_W     = 24;
  localparam int SUB_SLOTS = 32;
  localparam int POS_W     = $clog2(2 * SUB_SLOTS);

  typedef enum logic [1:0] {
    FMT_LJ     = 2'd0,
    FMT_I2S    = 2'd1,
    FMT_RJ     = 2'd2,
    FMT_LJ_ALT = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    PRE_BLK   = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_e;

  function automatic logic [4:0] word_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd16;
      2'd1:    return 5'd18;
      2'd2:    return 5'd20;
      default: return 5'd24;
    endcase
  endfunction

  // half-cell patterns, first half-cell in bit 7, for a preceding level of 0
  function automatic logic [7:0] pre_pattern(input pre_e p);
    case (p)
      PRE_BLK:  return 8'b1110_1000;
      PRE_LEFT: return 8'b1110_0010;
      default:  return 8'b1110_0100;
    endcase
  endfunction
endpackage

// File: rtl/abt_deser.sv
`timescale 1ns/1ps
module abt_deser
  import abt_pkg::*;
#(
  parameter int HALF_BITS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             ws_i,
  input  logic             sd_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       wsel_i,
  output logic             pair_vld_o,
  output logic [AUD_W-1:0] left_o,
  output logic [AUD_W-1:0] right_o
);
  localparam int IDX_W = $clog2(HALF_BITS);

  logic             sck_q, ws_q, synced_q, left_got_q;
  logic [IDX_W-1:0] idx_q, idx_nxt, tgt;
  logic [AUD_W-1:0] sh_q, sh_nxt, aligned, left_hold_q;
  logic             rise, ws_edge, cap;
  logic [4:0]       wlen, shamt;

  always_comb begin
    rise    = sck_i & ~sck_q;
    ws_edge = rise & (ws_i != ws_q);
    if (ws_edge)                               idx_nxt = '0;
    else if (idx_q == IDX_W'(HALF_BITS - 1))   idx_nxt = idx_q;
    else                                       idx_nxt = idx_q + 1'b1;
    sh_nxt  = {sh_q[AUD_W-2:0], sd_i};
    wlen    = word_len(wsel_i);
    shamt   = 5'(AUD_W) - wlen;
    aligned = sh_nxt << shamt;
    case (fmt_e'(fmt_i))
      FMT_I2S: tgt = IDX_W'(wlen);
      FMT_RJ:  tgt = IDX_W'(HALF_BITS - 1);
      default: tgt = IDX_W'(wlen - 5'd1);
    endcase
    cap = rise & (synced_q | ws_edge) & (idx_nxt == tgt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q       <= 1'b0;
      ws_q        <= 1'b0;
      synced_q    <= 1'b0;
      left_got_q  <= 1'b0;
      idx_q       <= '0;
      sh_q        <= '0;
      left_hold_q <= '0;
      pair_vld_o  <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
    end else begin
      sck_q      <= sck_i;
      pair_vld_o <= 1'b0;
      if (rise) begin
        ws_q  <= ws_i;
        idx_q <= idx_nxt;
        sh_q  <= sh_nxt;
        if (ws_edge) synced_q <= 1'b1;
      end
      if (cap) begin
        if (!ws_i) begin
          left_hold_q <= aligned;
          left_got_q  <= 1'b1;
        end else if (left_got_q) begin
          pair_vld_o <= 1'b1;
          left_o     <= left_hold_q;
          right_o    <= aligned;
          left_got_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/abt_frame_seq.sv
`timescale 1ns/1ps
module abt_frame_seq
  import abt_pkg::*;
#(
  parameter int FRAMES  = 192,
  parameter int CNT_W   = 7,
  parameter int FRAME_W = $clog2(FRAMES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pair_vld_i,
  input  logic [AUD_W-1:0]   left_i,
  input  logic [AUD_W-1:0]   right_i,
  input  logic               validity_i,
  output logic               active_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [AUD_W-1:0]   cur_left_o,
  output logic [AUD_W-1:0]   cur_right_o,
  output logic               cur_v_o
);
  logic [AUD_W-1:0] pend_l_q, pend_r_q;
  logic             pend_full_q, last, load;

  assign last = (cnt_o == '1);
  assign load = pend_full_q & (~active_o | last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l_q    <= '0;
      pend_r_q    <= '0;
      pend_full_q <= 1'b0;
      active_o    <= 1'b0;
      cnt_o       <= '0;
      frame_o     <= '0;
      cur_left_o  <= '0;
      cur_right_o <= '0;
      cur_v_o     <= 1'b0;
    end else begin
      if (pair_vld_i) begin
        pend_l_q <= left_i;
        pend_r_q <= right_i;
      end
      pend_full_q <= pair_vld_i | (pend_full_q & ~load);
      if (load) begin
        cur_left_o  <= pend_l_q;
        cur_right_o <= pend_r_q;
      end
      if (load | (active_o & last)) cur_v_o <= validity_i;
      if (!active_o) begin
        if (load) begin
          active_o <= 1'b1;
          cnt_o    <= '0;
          frame_o  <= '0;
        end
      end else begin
        cnt_o <= cnt_o + 1'b1;
        if (last) frame_o <= (frame_o == FRAME_W'(FRAMES - 1)) ? '0 : frame_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/abt_subframe.sv
`timescale 1ns/1ps
module abt_subframe
  import abt_pkg::*;
#(
  parameter int                FRAME_W    = 8,
  parameter int                CS_BITS    = 24,
  parameter logic [CS_BITS-1:0] CS_PATTERN = '0
) (
  input  logic [AUD_W-1:0]     sample_i,
  input  logic                 valid_i,
  input  logic [FRAME_W-1:0]   frame_i,
  output logic [SUB_SLOTS-1:0] bits_o
);
  logic          cs;
  logic [AUD_W+2:0] payload;

  always_comb begin
    cs = 1'b0;
    for (int k = 0; k < CS_BITS; k++) begin
      if (frame_i == FRAME_W'(k)) cs = CS_PATTERN[k];
    end
    payload = {cs, 1'b0, valid_i, sample_i};
    bits_o  = {^payload, payload, 4'b0000};
  end
endmodule

// File: rtl/abt_line_enc.sv
`timescale 1ns/1ps
module abt_line_enc
  import abt_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 active_i,
  input  logic [POS_W-1:0]     pos_i,
  input  pre_e                 pre_i,
  input  logic [SUB_SLOTS-1:0] bits_i,
  output logic                 line_o
);
  logic       inv_q, lvl;
  logic [7:0] pat;

  always_comb begin
    pat = pre_pattern(pre_i);
    if (pos_i < POS_W'(8))  lvl = pat[~pos_i[2:0]] ^ ((pos_i == '0) ? line_o : inv_q);
    else if (!pos_i[0])     lvl = ~line_o;
    else                    lvl = line_o ^ bits_i[pos_i[POS_W-1:1]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o <= 1'b0;
      inv_q  <= 1'b0;
    end else if (active_i) begin
      line_o <= lvl;
      if (pos_i == '0) inv_q <= line_o;
    end
  end
endmodule

// File: rtl/aes_bmc_tx.sv
`timescale 1ns/1ps
module aes_bmc_tx
  import abt_pkg::*;
#(
  parameter int                 HALF_BITS        = 32,
  parameter int                 FRAMES_PER_BLOCK = 192,
  parameter int                 CS_BITS          = 24,
  parameter logic [CS_BITS-1:0] CS_PATTERN       = 24'h000204
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       ws_i,
  input  logic       sd_i,
  input  logic [1:0] fmt_i,
  input  logic [1:0] wsel_i,
  input  logic       validity_i,
  output logic       line_o
);
  localparam int CNT_W   = POS_W + 1;
  localparam int FRAME_W = $clog2(FRAMES_PER_BLOCK);

  logic                 pair_vld, enc_active, cur_v;
  logic [AUD_W-1:0]     dl, dr, cur_l, cur_r, sample_sel;
  logic [CNT_W-1:0]     enc_cnt;
  logic [FRAME_W-1:0]   frame_idx;
  logic [SUB_SLOTS-1:0] sub_bits;
  pre_e                 pre_sel;

  abt_deser #(.HALF_BITS(HALF_BITS)) u_deser (
    .clk_i, .rst_ni, .sck_i, .ws_i, .sd_i, .fmt_i, .wsel_i,
    .pair_vld_o(pair_vld), .left_o(dl), .right_o(dr)
  );

  abt_frame_seq #(.FRAMES(FRAMES_PER_BLOCK), .CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_seq (
    .clk_i, .rst_ni, .pair_vld_i(pair_vld), .left_i(dl), .right_i(dr),
    .validity_i, .active_o(enc_active), .cnt_o(enc_cnt), .frame_o(frame_idx),
    .cur_left_o(cur_l), .cur_right_o(cur_r), .cur_v_o(cur_v)
  );

  always_comb begin
    sample_sel = enc_cnt[CNT_W-1] ? cur_r : cur_l;
    if (enc_cnt[CNT_W-1])     pre_sel = PRE_RIGHT;
    else if (frame_idx == '0) pre_sel = PRE_BLK;
    else                      pre_sel = PRE_LEFT;
  end

  abt_subframe #(.FRAME_W(FRAME_W), .CS_BITS(CS_BITS), .CS_PATTERN(CS_PATTERN)) u_sub (
    .sample_i(sample_sel), .valid_i(cur_v), .frame_i(frame_idx), .bits_o(sub_bits)
  );

  abt_line_enc u_enc (
    .clk_i, .rst_ni, .active_i(enc_active), .pos_i(enc_cnt[POS_W-1:0]),
    .pre_i(pre_sel), .bits_i(sub_bits), .line_o
  );
endmodule

// File: rtl/abt_checker.sv
`timescale 1ns/1ps
module abt_checker #(
  parameter int CNT_W   = 7,
  parameter int FRAME_W = 8,
  parameter int FRAMES  = 192
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               active_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic               line_i
);
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !line_i);  // R1
  AST_SUBFRAME_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_i[CNT_W-2:0] == '0) |=> line_i);  // R6
  AST_CELL_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_i[CNT_W-2:3] != '0 && !cnt_i[0]) |=> (line_i != $past(line_i)));  // R8
  AST_BLOCK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i < FRAME_W'(FRAMES));  // R7
  AST_START_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_i) |-> (cnt_i == '0 && frame_i == '0));  // R7
endmodule

bind aes_bmc_tx abt_checker #(.CNT_W(CNT_W), .FRAME_W(FRAME_W), .FRAMES(FRAMES_PER_BLOCK)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .active_i(enc_active), .cnt_i(enc_cnt),
  .frame_i(frame_idx), .line_i(line_o)
);

// File: tb/aes_bmc_tx_tb_top.sv
`timescale 1ns/1ps
module aes_bmc_tx_tb_top;
  localparam logic [23:0] CS_VAL = 24'h5A0C31;

  logic clk_i = 1'b0, rst_ni = 1'b0, sck = 1'b0, ws = 1'b1, sd = 1'b0, validity = 1'b0;
  logic [1:0] fmt = 2'd0, wsel = 2'd0;
  logic line_o;

  int checks = 0, fails = 0;
  int raw_l[0:255], raw_r[0:255];
  int seg_frames = 0, seg_w = 16, dec_subs = 0;
  bit seg_v = 1'b0, dec_on = 1'b0;
  string seg_tag = "R2";

  always #2 clk_i = ~clk_i;

  aes_bmc_tx #(.CS_PATTERN(CS_VAL)) dut_i (
    .clk_i, .rst_ni, .sck_i(sck), .ws_i(ws), .sd_i(sd), .fmt_i(fmt),
    .wsel_i(wsel), .validity_i(validity), .line_o
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bit_at(int f, int w, int word, int i);
    if (f == 1) return (i >= 1 && i <= w) ? word[w-i] : 1'b0;
    if (f == 2) return (i >= 32 - w) ? word[31-i] : 1'b0;
    return (i < w) ? word[w-1-i] : 1'b0;
  endfunction

  function automatic logic [7:0] exp_pre(bit right, bit blk);
    if (right) return 8'b1110_0100;
    return blk ? 8'b1110_1000 : 8'b1110_0010;
  endfunction

  // line decoder, one half-cell per clock
  logic [63:0] hc;
  logic prev_lvl = 1'b0;
  bit   started = 1'b0;
  int   pos = 0, sub = 0;

  task automatic decode_sub(int s);
    int f, fb, idx, e;
    bit ch, bnd_ok;
    logic [31:0] b;
    logic [7:0] gp, ep;
    f = s / 2; ch = s[0]; fb = f % 192;
    idx = (f < seg_frames) ? f : seg_frames - 1;
    e = ((ch ? raw_r[idx] : raw_l[idx]) << (24 - seg_w)) & 32'hFFFFFF;
    for (int i = 0; i < 8; i++) gp[7-i] = hc[i];
    ep = exp_pre(ch, fb == 0) ^ {8{prev_lvl}};
    check(gp == ep, (fb == 0 && !ch) ? "R7 block-start preamble" : "R7 preamble", gp, ep);
    bnd_ok = 1'b1;
    for (int k = 4; k < 32; k++) if (hc[2*k] == hc[2*k-1]) bnd_ok = 1'b0;
    check(bnd_ok, "R8 boundary transitions", bnd_ok, 1);
    b = '0;
    for (int k = 4; k < 32; k++) b[k] = hc[2*k] ^ hc[2*k+1];
    check(b[27:4] == e[23:0], (f < seg_frames) ? {seg_tag, "/R5 audio"} : "R10 repeated audio",
          b[27:4], e[23:0]);
    check(b[28] == seg_v, "R6 validity slot", b[28], seg_v);
    check(b[29] == 1'b0, "R6 user slot", b[29], 0);
    check(b[30] == ((fb < 24) ? CS_VAL[fb] : 1'b0), "R9 channel status", b[30],
          (fb < 24) ? CS_VAL[fb] : 1'b0);
    check(^b[31:4] == 1'b0, "R6 even parity", b[31:4], 0);
    dec_subs++;
  endtask

  always @(negedge clk_i) begin
    if (!dec_on) begin
      started = 1'b0; pos = 0; sub = 0; prev_lvl = 1'b0;
    end else if (!started) begin
      if (line_o) begin
        started = 1'b1; hc[0] = 1'b1; pos = 1;
      end
    end else begin
      hc[pos] = line_o;
      pos++;
      if (pos == 64) begin
        if (sub < 2 * (seg_frames + 2)) decode_sub(sub);
        sub++;
        pos = 0;
        prev_lvl = hc[63];
      end
    end
  end

  task automatic send_half(bit ch, int word, int f, int w);
    for (int i = 0; i < 32; i++) begin
      @(posedge clk_i); #1;
      sck = 1'b0; ws = ch; sd = bit_at(f, w, word, i);
      @(posedge clk_i); #1;
      sck = 1'b1;
    end
  endtask

  task automatic run_seg(int f, int wcode, bit v, int nfr, string tag);
    int w, mask;
    w = (wcode == 0) ? 16 : (wcode == 1) ? 18 : (wcode == 2) ? 20 : 24;
    mask = (1 << w) - 1;
    dec_on = 1'b0;
    rst_ni = 1'b0; sck = 1'b0; ws = 1'b1; sd = 1'b0;
    fmt = 2'(f); wsel = 2'(wcode); validity = v;
    repeat (4) @(posedge clk_i);
    @(negedge clk_i);
    check(line_o == 1'b0, "R1 line low in reset", line_o, 0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    for (int k = 0; k < nfr; k++) begin
      raw_l[k] = $urandom & mask;
      raw_r[k] = $urandom & mask;
    end
    raw_l[0] = mask;          raw_r[0] = 1;
    raw_l[1] = 1 << (w - 1);  raw_r[1] = 0;
    seg_frames = nfr; seg_w = w; seg_v = v; seg_tag = tag; dec_subs = 0;
    dec_on = 1'b1;
    send_half(1'b1, 0, f, w);
    @(negedge clk_i);
    check(line_o == 1'b0, "R1 line low before first pair", line_o, 0);
    for (int k = 0; k < nfr; k++) begin
      send_half(1'b0, raw_l[k], f, w);
      send_half(1'b1, raw_r[k], f, w);
    end
    repeat (700) @(posedge clk_i);
    check(dec_subs == 2 * (nfr + 2), "R10 subframes decoded", dec_subs, 2 * (nfr + 2));
    dec_on = 1'b0;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h00C0FFEE);
    for (int f = 0; f < 3; f++) begin
      for (int wc = 0; wc < 4; wc++) begin
        run_seg(f, wc, 1'((f + wc) % 2), 6, (f == 0) ? "R2" : (f == 1) ? "R3" : "R4");
      end
    end
    run_seg(3, 1, 1'b1, 6, "R2");
    run_seg(1, 3, 1'b1, 200, "R3");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule